// File: doc/BRIEF.md
# Escaped Byte-Stream Packet Decoder

This block sits behind a serial receiver and turns a raw byte stream into framed packets. Each incoming byte arrives with a valid flag. The decoder discards filler bytes and removes two independent escape layers, each with its own escape code. It strips the framing markers and emits data bytes with start-of-packet and end-of-packet flags, together with the channel number that the packet announced.

The framing puts the end-of-packet marker ahead of the final data byte, not after it. Filler may appear anywhere, even between an escape code and the byte it protects.

Protocol violations set a sticky error flag. After a violation the decoder ignores the rest of the packet until the next start marker. That marker, or reset, clears the flag. The decoder never interprets the payload.

Top module: `esc_stream_decoder`

## Requirements
- R1: After reset, `out_valid_o`, `out_sop_o`, `out_eop_o` and `err_o` are 0, and `out_chan_o` is 0.
- R2: Byte 0x4A is filler. It is discarded everywhere and never appears on the output. This holds inside a packet, between an escape code and its byte, and between a channel marker and the channel number.
- R3: Either escape code, 0x4D or 0x7D, makes the next non-filler byte a data byte. That byte is output XORed with 0x20.
- R4: The markers 0x7A (start), 0x7B (end) and 0x7C (channel) are never output as data. Bytes received outside a packet are dropped, except a start marker. "Outside a packet" means before the first start marker, after a packet completes, or after an error.
- R5: The first data byte after a start marker is output with `out_sop_o` set. Later bytes of the same packet have `out_sop_o` clear.
- R6: After an end marker, the next data byte is output with `out_eop_o` set, after any unescaping. That byte completes the packet.
- R7: A start marker always restarts parsing. This includes a start marker inside a packet and one directly after an escape code. The partial packet, any pending escape, any pending end marker and the channel number are discarded. The next data byte carries `out_sop_o` again.
- R8: Each of the following sets `err_o` and drops the rest of the packet:
  - an end or channel marker directly after an escape code;
  - an end or channel marker after an end marker;
  - an escape code directly after an escape code.
- R9: The first non-filler byte after a channel marker is taken raw as the channel number and is not output. A value above `MAX_CHAN` (default 0) is an error under R8's handling. An accepted value appears on `out_chan_o` for the packet's later data bytes.
- R10: `err_o` stays set until a start marker is received or reset is applied. A start marker clears it.
- R11: A data byte presented with `in_valid_i` high at one clock edge appears on the outputs after that edge, with `out_valid_o` high for exactly that cycle. `out_valid_o` is low in every cycle that follows a filler byte, a marker, or a cycle with no input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input byte valid |
| in_byte_i | input | 8 | Raw received byte |
| out_valid_o | output | 1 | Output data byte valid |
| out_data_o | output | 8 | Unescaped data byte |
| out_sop_o | output | 1 | First data byte of a packet |
| out_eop_o | output | 1 | Last data byte of a packet |
| out_chan_o | output | CHAN_W | Channel number of the current packet |
| err_o | output | 1 | Sticky protocol error flag |

## Verification
The hardest situations to reach are escape and end-marker state carried across filler bytes, combined with a start marker that arrives while an escape or end marker is pending. Well-formed packets rarely produce these. The stimulus therefore mixes directed sequences with a long random stream drawn from a weighted alphabet. In that alphabet, markers, escape codes, filler and zero bytes are far more common than in real traffic, so pending-escape and pending-end cases collide with restarts, errors and channel bytes many times. Each byte is compared against a bench reference model.

// File: rtl/esc_dec_pkg.sv
`timescale 1ns/1ps
package esc_dec_pkg;
  localparam logic [7:0] BYTE_SOP    = 8'h7A;
  localparam logic [7:0] BYTE_EOP    = 8'h7B;
  localparam logic [7:0] BYTE_CHAN   = 8'h7C;
  localparam logic [7:0] BYTE_PESC   = 8'h7D;
  localparam logic [7:0] BYTE_IDLE   = 8'h4A;
  localparam logic [7:0] BYTE_XESC   = 8'h4D;
  localparam logic [7:0] UNESC_MASK  = 8'h20;

  typedef enum logic [2:0] {
    KIND_DATA, KIND_IDLE, KIND_SOP, KIND_EOP, KIND_CHAN, KIND_ESC
  } byte_kind_e;

  typedef struct packed {
    logic active;   // inside an accepted packet
    logic esc;      // escape pending
    logic eop;      // end marker seen
    logic chp;      // channel number pending
    logic first;    // next data byte is first
  } frame_state_t;
endpackage

// File: rtl/esc_byte_classify.sv
`timescale 1ns/1ps
module esc_byte_classify
  import esc_dec_pkg::*;
(
  input  logic [7:0]  byte_i,
  output byte_kind_e  kind_o
);
  always_comb begin
    case (byte_i)
      BYTE_IDLE:            kind_o = KIND_IDLE;
      BYTE_SOP:             kind_o = KIND_SOP;
      BYTE_EOP:             kind_o = KIND_EOP;
      BYTE_CHAN:            kind_o = KIND_CHAN;
      BYTE_PESC, BYTE_XESC: kind_o = KIND_ESC;
      default:              kind_o = KIND_DATA;
    endcase
  end
endmodule

// File: rtl/esc_frame_ctrl.sv
`timescale 1ns/1ps
module esc_frame_ctrl
  import esc_dec_pkg::*;
#(
  parameter int MAX_CHAN = 0,
  parameter int CHAN_W   = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [7:0]        byte_i,
  input  byte_kind_e        kind_i,
  output logic              emit_o,
  output logic [7:0]        emit_data_o,
  output logic              emit_sop_o,
  output logic              emit_eop_o,
  output logic [CHAN_W-1:0] chan_o,
  output logic              err_o
);
  frame_state_t st_q, st_d;
  logic              err_q, err_d;
  logic [CHAN_W-1:0] chan_q, chan_d;
  logic              fail;

  always_comb begin
    st_d        = st_q;
    err_d       = err_q;
    chan_d      = chan_q;
    fail        = 1'b0;
    emit_o      = 1'b0;
    emit_data_o = byte_i;
    emit_sop_o  = 1'b0;
    emit_eop_o  = 1'b0;
    if (valid_i) begin
      if (kind_i == KIND_SOP) begin
        st_d   = '{active: 1'b1, esc: 1'b0, eop: 1'b0, chp: 1'b0, first: 1'b1};
        err_d  = 1'b0;
        chan_d = '0;
      end else if (st_q.active && kind_i != KIND_IDLE) begin
        if (st_q.chp) begin
          st_d.chp = 1'b0;
          if (int'(byte_i) > MAX_CHAN) fail = 1'b1;
          else chan_d = byte_i[CHAN_W-1:0];
        end else begin
          case (kind_i)
            KIND_EOP: begin
              if (st_q.esc || st_q.eop) fail = 1'b1;
              else st_d.eop = 1'b1;
            end
            KIND_CHAN: begin
              if (st_q.esc || st_q.eop) fail = 1'b1;
              else st_d.chp = 1'b1;
            end
            KIND_ESC: begin
              if (st_q.esc) fail = 1'b1;
              else st_d.esc = 1'b1;
            end
            default: begin
              emit_o      = 1'b1;
              emit_data_o = st_q.esc ? (byte_i ^ UNESC_MASK) : byte_i;
              emit_sop_o  = st_q.first;
              emit_eop_o  = st_q.eop;
              st_d.esc    = 1'b0;
              st_d.first  = 1'b0;
              if (st_q.eop) st_d.active = 1'b0;
            end
          endcase
        end
        if (fail) begin
          err_d       = 1'b1;
          st_d.active = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= '0;
      err_q  <= 1'b0;
      chan_q <= '0;
    end else begin
      st_q   <= st_d;
      err_q  <= err_d;
      chan_q <= chan_d;
    end
  end

  assign chan_o = chan_q;
  assign err_o  = err_q;
endmodule

// File: rtl/esc_out_stage.sv
`timescale 1ns/1ps
module esc_out_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              sop_i,
  input  logic              eop_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              sop_o,
  output logic              eop_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      sop_o   <= 1'b0;
      eop_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      sop_o   <= valid_i & sop_i;
      eop_o   <= valid_i & eop_i;
      if (valid_i) data_o <= data_i;
    end
  end
endmodule

// File: rtl/esc_stream_decoder.sv
`timescale 1ns/1ps
module esc_stream_decoder
  import esc_dec_pkg::*;
#(
  parameter int MAX_CHAN = 0,
  localparam int CHAN_W  = (MAX_CHAN < 1) ? 1 : $clog2(MAX_CHAN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [7:0]        in_byte_i,
  output logic              out_valid_o,
  output logic [7:0]        out_data_o,
  output logic              out_sop_o,
  output logic              out_eop_o,
  output logic [CHAN_W-1:0] out_chan_o,
  output logic              err_o
);
  byte_kind_e kind;
  logic       emit, emit_sop, emit_eop;
  logic [7:0] emit_data;

  esc_byte_classify i_classify (
    .byte_i (in_byte_i),
    .kind_o (kind)
  );

  esc_frame_ctrl #(.MAX_CHAN(MAX_CHAN), .CHAN_W(CHAN_W)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (in_valid_i),
    .byte_i      (in_byte_i),
    .kind_i      (kind),
    .emit_o      (emit),
    .emit_data_o (emit_data),
    .emit_sop_o  (emit_sop),
    .emit_eop_o  (emit_eop),
    .chan_o      (out_chan_o),
    .err_o       (err_o)
  );

  esc_out_stage #(.DATA_W(8)) i_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (emit),
    .data_i  (emit_data),
    .sop_i   (emit_sop),
    .eop_i   (emit_eop),
    .valid_o (out_valid_o),
    .data_o  (out_data_o),
    .sop_o   (out_sop_o),
    .eop_o   (out_eop_o)
  );
endmodule

// File: rtl/esc_stream_decoder_chk.sv
`timescale 1ns/1ps
module esc_stream_decoder_chk
  import esc_dec_pkg::*;
#(
  parameter int MAX_CHAN = 0,
  localparam int CHAN_W  = (MAX_CHAN < 1) ? 1 : $clog2(MAX_CHAN + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic [7:0]        in_byte_i,
  input logic              out_valid_o,
  input logic [7:0]        out_data_o,
  input logic              out_sop_o,
  input logic              out_eop_o,
  input logic [CHAN_W-1:0] out_chan_o,
  input logic              err_o
);
  // R2
  idle_dropped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_byte_i == BYTE_IDLE) |=> !out_valid_o);

  // R4
  marker_dropped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && (in_byte_i == BYTE_SOP || in_byte_i == BYTE_EOP ||
     in_byte_i == BYTE_CHAN)) |=> !out_valid_o);

  // R10
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !(in_valid_i && in_byte_i == BYTE_SOP)) |=> err_o);

  // R10
  sop_clears_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_byte_i == BYTE_SOP) |=> !err_o);

  // R11
  out_needs_input_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);

  // R11
  flags_need_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> (!out_sop_o && !out_eop_o));
endmodule

bind esc_stream_decoder esc_stream_decoder_chk #(.MAX_CHAN(MAX_CHAN)) i_chk (.*);

// File: tb/test_esc_stream_decoder.sv
`timescale 1ns/1ps
module test_esc_stream_decoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       out_valid, out_sop, out_eop, err;
  logic [7:0] out_data;
  logic [0:0] out_chan;

  always #2.5 clk = ~clk;

  esc_stream_decoder i_esc_stream_decoder (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_byte_i(in_byte),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_sop_o(out_sop),
    .out_eop_o(out_eop), .out_chan_o(out_chan), .err_o(err)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // reference model state
  bit m_act, m_esc, m_eop, m_chp, m_first, m_err;
  bit e_valid, e_sop, e_eop;
  logic [7:0] e_data;
  string tag;

  function automatic bit is_esc(logic [7:0] b);
    return b == 8'h4D || b == 8'h7D;
  endfunction

  task automatic model(input logic [7:0] b);
    bit fail = 0;
    e_valid = 0; e_sop = 0; e_eop = 0;
    tag = "R4";
    if (b == 8'h7A) begin
      m_act = 1; m_esc = 0; m_eop = 0; m_chp = 0; m_first = 1; m_err = 0;
      tag = "R7";
    end else if (!m_act) begin
      tag = "R4";
    end else if (b == 8'h4A) begin
      tag = "R2";
    end else if (m_chp) begin
      m_chp = 0; tag = "R9";
      if (b != 8'h00) fail = 1;
    end else if (b == 8'h7B || b == 8'h7C) begin
      if (m_esc || m_eop) fail = 1;
      else if (b == 8'h7B) m_eop = 1;
      else m_chp = 1;
    end else if (is_esc(b)) begin
      tag = "R3";
      if (m_esc) fail = 1;
      else m_esc = 1;
    end else begin
      e_valid = 1;
      e_data  = m_esc ? (b ^ 8'h20) : b;
      e_sop   = m_first;
      e_eop   = m_eop;
      tag = m_eop ? "R6" : (m_esc ? "R3" : (m_first ? "R5" : "R11"));
      m_esc = 0; m_first = 0;
      if (m_eop) m_act = 0;
    end
    if (fail) begin m_err = 1; m_act = 0; tag = "R8"; end
  endtask

  task automatic compare(input bit xv);
    n_cmp++;
    if (out_valid !== e_valid || (e_valid &&
        (out_data !== e_data || out_sop !== e_sop || out_eop !== e_eop || out_chan !== 1'b0))) begin
      n_bad++;
      $display("FAIL %s: out v=%0b d=%h s=%0b e=%0b c=%0b, exp v=%0b d=%h s=%0b e=%0b c=0 (byte valid %0b)",
               tag, out_valid, out_data, out_sop, out_eop, out_chan, e_valid, e_data, e_sop, e_eop, xv);
    end
    n_cmp++;
    if (err !== m_err) begin
      n_bad++;
      $display("FAIL R10/%s: err=%0b exp=%0b", tag, err, m_err);
    end
  endtask

  task automatic push(input logic [7:0] b);
    model(b);
    in_valid = 1; in_byte = b;
    @(posedge clk); #1;
    in_valid = 0;
    compare(1);
  endtask

  task automatic gap();
    e_valid = 0; e_sop = 0; e_eop = 0; tag = "R11";
    in_valid = 0; in_byte = $urandom;
    @(posedge clk); #1;
    compare(0);
  endtask

  // encode a data byte with the given escape code when needed
  task automatic push_data(input logic [7:0] d, input logic [7:0] escc);
    if (d inside {8'h7A, 8'h7B, 8'h7C, 8'h7D, 8'h4A, 8'h4D}) begin
      push(escc); push(d ^ 8'h20);
    end else push(d);
  endtask

  task automatic packet(input int len, input bit idles);
    push(8'h7A); push(8'h7C);
    if (idles) push(8'h4A);
    push(8'h00);
    for (int i = 0; i < len; i++) begin
      logic [7:0] d;
      d = ($urandom_range(0, 3) == 0) ? 8'h7A + 8'($urandom_range(0, 3)) : 8'($urandom);
      if (idles && $urandom_range(0, 3) == 0) push(8'h4A);
      if (i == len - 1) push(8'h7B);
      push_data(d, $urandom_range(0, 1) ? 8'h7D : 8'h4D);
    end
  endtask

  initial begin
    #20000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    n_cmp++;
    if (out_valid !== 0 || out_sop !== 0 || out_eop !== 0 || err !== 0 || out_chan !== 0) begin
      n_bad++;
      $display("FAIL R1: v=%0b s=%0b e=%0b err=%0b c=%0b exp all 0", out_valid, out_sop, out_eop, err, out_chan);
    end
    rst_n = 1;
    @(posedge clk); #1;

    // R4: garbage before first start marker
    push(8'h11); push(8'h7B); push(8'h4D); push(8'h55);
    // R5/R6: single-byte packet, EOP before the only data byte
    push(8'h7A); push(8'h7B); push(8'h42);
    // R4: bytes after completed packet dropped
    push(8'h33);
    // R2/R3: escape, idle, escaped byte, both escape codes
    push(8'h7A); push(8'h4D); push(8'h4A); push(8'h6A); push(8'h7D); push(8'h5A);
    // R9: idle between channel marker and channel number
    push(8'h7C); push(8'h4A); push(8'h00); push(8'h01);
    // R6: escape after EOP, escaped last byte
    push(8'h7B); push(8'h7D); push(8'h5B);
    // R8: double escape, then ignored bytes until start
    push(8'h7A); push(8'h10); push(8'h7D); push(8'h4D); push(8'h20); push(8'h7B);
    // R10/R7: start clears error
    push(8'h7A); push(8'h21);
    // R8: end marker after escape
    push(8'h7D); push(8'h7B); push(8'h22);
    // R8: end after end; channel after end
    push(8'h7A); push(8'h7B); push(8'h7B);
    push(8'h7A); push(8'h7B); push(8'h7C);
    // R9: nonzero channel number
    push(8'h7A); push(8'h7C); push(8'h03); push(8'h44);
    // R7: start after pending escape and pending end
    push(8'h7A); push(8'h01); push(8'h7B); push(8'h7D); push(8'h7A); push(8'h5A); push(8'h02);
    gap();

    // well-formed packets
    for (int p = 0; p < 60; p++) begin
      packet($urandom_range(1, 12), p[0]);
      if ($urandom_range(0, 1) == 0) gap();
    end

    // weighted random stream
    for (int k = 0; k < 6000; k++) begin
      int r;
      logic [7:0] b;
      r = $urandom_range(0, 99);
      if (r < 8)       b = 8'h7A;
      else if (r < 14) b = 8'h7B;
      else if (r < 18) b = 8'h7C;
      else if (r < 24) b = 8'h7D;
      else if (r < 30) b = 8'h4D;
      else if (r < 40) b = 8'h4A;
      else if (r < 50) b = 8'h00;
      else             b = 8'($urandom);
      if ($urandom_range(0, 9) == 0) gap();
      else push(b);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule